// File: doc/BRIEF.md
# Multi-mode DMA channel sequencer

This block sequences a small set of DMA channels. Each channel holds a control word, a word count and a source and a destination address. It waits for a trigger and then hands single-word copy commands to a memory port, at most one word per clock. The trigger is a rising edge on a request line that the channel selects, or the enable write itself in the software-start mode. A three-bit mode selects how much moves per trigger: one word, or a whole block, where a line is the same as a block under one-dimensional addressing. The mode also selects whether the channel disarms itself when its block ends.

Software programs the channels through a narrow write port. Per-channel done flags and completion interrupts report the end of a block or a software disable. An activity flag and the number of the channel being served show what the sequencer is doing. When several channels are running, the lowest-numbered one takes each word slot.

Top module: `dma_seq_ctrl`

## Requirements
- R1: A write with `cfg_we` high loads one register of channel `cfg_ch`. `cfg_sel` picks the register: 0 is control, 1 is word count, 2 is source address, 3 is destination address. The control word bits are: bit 0 enable, bit 1 interrupt enable, bits 4:2 mode, bits 9:5 request source, bit 10 source increment, bit 11 destination increment.
- R2: In modes 000 (block) and 010 (line, identical to block), each rising edge of the selected request line starts a whole block. The first command appears on the memory port two clock edges after the edge is sampled, and one word follows per cycle. At block end the enable bit clears and the done flag sets.
- R3: In mode 001 (word), each request edge moves exactly one word. The done flag sets only after the last word of the block.
- R4: In mode 011 (software start), setting the enable bit starts the block with no request. Request edges do not start it.
- R5: In modes 1xx, the enable bit stays set at block end and the channel waits for the next trigger. The done flag is not set at block end, so no interrupt is raised.
- R6: A request-source code of NREQ or above (20 to 31 by default) selects no line. An enabled channel with such a code never starts.
- R7: The word counter loads from the count register when the channel is enabled, and it reloads after the last word of a block. A count of N moves N words, and a count of 0 moves one word.
- R8: After each word, the source and the destination address each step up by one if their increment bit is set, and otherwise stay fixed. The addresses carry over from block to block.
- R9: Enabling a channel clears its done flag. `irq[i]` is high exactly when channel i has its interrupt enable set and its done flag set.
- R10: Clearing the enable bit lets a word granted in the same cycle complete. The channel then stops, and its done flag is set one clock later.
- R11: When several channels are running, the lowest-numbered one is served first. At most one word command is issued per cycle.
- R12: `active` is high while any channel is running, and `active_ch` gives the lowest-numbered running channel.
- R13: After reset, every channel is disabled with done flags clear, and the memory port, `irq` and `active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 2 | Register select within the channel |
| cfg_wdata | input | AW | Write data |
| req | input | NREQ | Peripheral request lines |
| xfer_valid | output | 1 | Word copy command valid |
| xfer_ch | output | 3 | Channel issuing the command |
| xfer_src | output | AW | Source word address |
| xfer_dst | output | AW | Destination word address |
| done | output | NCH | Per-channel done flags |
| irq | output | NCH | Per-channel completion interrupts |
| active | output | 1 | Some channel is running |
| active_ch | output | 3 | Lowest-numbered running channel |

## Verification
The hardest case to reach is a software disable in the middle of a running block, because the disable write must land on an edge where the channel is also being granted a word. The bench times the write from the request pulse, so the disable arrives on the edge that grants the third word of an eight-word block. It then expects exactly three commands and a done flag one cycle later. Two channels are also triggered from one shared request line to force contention. The scoreboard order then exposes the priority, and the status outputs are sampled on the cycles where service passes from one channel to the next.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int CTRL_W = 12;

  typedef struct packed {
    logic       dinc;
    logic       sinc;
    logic [4:0] rsel;
    logic [2:0] mode;
    logic       ie;
    logic       en;
  } ctrl_t;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_SRC   = 2'd2;
  localparam logic [1:0] SEL_DST   = 2'd3;

  function automatic logic mode_is_word(input logic [2:0] m);
    return m[1:0] == 2'b01;
  endfunction

  function automatic logic mode_is_swstart(input logic [2:0] m);
    return m == 3'b011;
  endfunction

  function automatic logic mode_stays_armed(input logic [2:0] m);
    return m[2];
  endfunction
endpackage

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
  import dma_seq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREQ = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic [NREQ-1:0] req,
  input  logic            grant,
  output logic            want,
  output logic [AW-1:0]   src_addr,
  output logic [AW-1:0]   dst_addr,
  output logic            done,
  output logic            irq
);
  localparam int RSPACE = 32;

  ctrl_t             ctrl;
  ctrl_t             wr_ctrl;
  logic [AW-1:0]     cnt_init;
  logic [AW-1:0]     cnt;
  logic              run;
  logic              req_prev;
  logic              req_sel;
  logic              trig;
  logic              last;
  logic [RSPACE-1:0] req_pad;
  logic              wr_ctl;

  assign wr_ctrl = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
  assign wr_ctl  = cfg_we && (cfg_sel == SEL_CTRL);
  assign req_pad = {{(RSPACE-NREQ){1'b0}}, req};
  assign req_sel = req_pad[ctrl.rsel];
  assign trig    = req_sel && !req_prev && !mode_is_swstart(ctrl.mode);
  assign last    = cnt <= AW'(1);
  assign want    = run;
  assign irq     = ctrl.ie && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      cnt_init <= '0;
      cnt      <= '0;
      src_addr <= '0;
      dst_addr <= '0;
      run      <= 1'b0;
      done     <= 1'b0;
      req_prev <= 1'b0;
    end else begin
      req_prev <= req_sel;
      if (ctrl.en && !run && trig)
        run <= 1'b1;
      if (grant) begin
        src_addr <= src_addr + AW'(ctrl.sinc);
        dst_addr <= dst_addr + AW'(ctrl.dinc);
        if (last) begin
          cnt <= cnt_init;
          run <= 1'b0;
          if (!mode_stays_armed(ctrl.mode)) begin
            ctrl.en <= 1'b0;
            done    <= 1'b1;
          end
        end else begin
          cnt <= cnt - AW'(1);
          if (mode_is_word(ctrl.mode))
            run <= 1'b0;
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          SEL_CTRL: begin
            ctrl.ie   <= wr_ctrl.ie;
            ctrl.mode <= wr_ctrl.mode;
            ctrl.rsel <= wr_ctrl.rsel;
            ctrl.sinc <= wr_ctrl.sinc;
            ctrl.dinc <= wr_ctrl.dinc;
            if (wr_ctrl.en && !ctrl.en) begin
              ctrl.en <= 1'b1;
              done    <= 1'b0;
              cnt     <= cnt_init;
              run     <= mode_is_swstart(wr_ctrl.mode);
            end else if (!wr_ctrl.en && ctrl.en) begin
              ctrl.en <= 1'b0;
              run     <= 1'b0;
              done    <= 1'b1;
            end
          end
          SEL_COUNT: cnt_init <= cfg_wdata;
          SEL_SRC:   src_addr <= cfg_wdata;
          default:   dst_addr <= cfg_wdata;
        endcase
      end
    end
  end

  AST_DISABLE_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !wr_ctrl.en && ctrl.en) |=> (done && !run)); // R10
  AST_ENABLE_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && wr_ctrl.en && !ctrl.en) |=> !done); // R9
  AST_RESERVED_NEVER_RUNS: assert property (@(posedge clk) disable iff (rst)
    (!run && !cfg_we && (int'(ctrl.rsel) >= NREQ)) |=> !run); // R6
  AST_COUNT_RELOADS: assert property (@(posedge clk) disable iff (rst)
    (grant && last && !cfg_we) |=> (cnt == $past(cnt_init))); // R7
  AST_ARMED_KEEPS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (grant && last && ctrl.mode[2] && !cfg_we) |=> (ctrl.en && $stable(done))); // R5
endmodule

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
  parameter int N  = 4,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  want,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (want[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IW'(i);
      end
    end
  end
  assign any = |want;

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R11
  AST_GRANT_WHEN_WANTED: assert property (@(posedge clk) disable iff (rst)
    any |-> ((grant & want) == grant) && (grant != '0)); // R11
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int AW   = 16,
  parameter int NREQ = 20,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic [NREQ-1:0] req,
  output logic            xfer_valid,
  output logic [2:0]      xfer_ch,
  output logic [AW-1:0]   xfer_src,
  output logic [AW-1:0]   xfer_dst,
  output logic [NCH-1:0]  done,
  output logic [NCH-1:0]  irq,
  output logic            active,
  output logic [2:0]      active_ch
);
  logic [NCH-1:0] want;
  logic [NCH-1:0] grant;
  logic [2:0]     gidx;
  logic           gany;
  logic [AW-1:0]  ch_src [NCH];
  logic [AW-1:0]  ch_dst [NCH];
  logic [AW-1:0]  sel_src;
  logic [AW-1:0]  sel_dst;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_seq_chan #(.AW(AW), .NREQ(NREQ)) i_chan (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we && (cfg_ch == CHW'(g))),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .req      (req),
      .grant    (grant[g]),
      .want     (want[g]),
      .src_addr (ch_src[g]),
      .dst_addr (ch_dst[g]),
      .done     (done[g]),
      .irq      (irq[g])
    );
  end

  dma_seq_arb #(.N(NCH), .IW(3)) i_arb (
    .clk  (clk),
    .rst  (rst),
    .want (want),
    .grant(grant),
    .idx  (gidx),
    .any  (gany)
  );

  always_comb begin
    sel_src = '0;
    sel_dst = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        sel_src = ch_src[i];
        sel_dst = ch_dst[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_valid <= 1'b0;
      xfer_ch    <= '0;
      xfer_src   <= '0;
      xfer_dst   <= '0;
    end else begin
      xfer_valid <= gany;
      if (gany) begin
        xfer_ch  <= gidx;
        xfer_src <= sel_src;
        xfer_dst <= sel_dst;
      end
    end
  end

  assign active    = gany;
  assign active_ch = gidx;

  AST_CMD_FOLLOWS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> $past(active)); // R12
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    (irq & ~done) == '0); // R9
endmodule

// File: tb/test_dma_seq_ctrl.sv
module test_dma_seq_ctrl;
  localparam int NCH = 4;
  localparam int AW = 16;
  localparam int NREQ = 20;

  typedef struct {
    int ch;
    int src;
    int dst;
  } item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_ch = '0;
  logic [1:0]      cfg_sel = '0;
  logic [AW-1:0]   cfg_wdata = '0;
  logic [NREQ-1:0] req = '0;
  logic            xfer_valid;
  logic [2:0]      xfer_ch;
  logic [AW-1:0]   xfer_src;
  logic [AW-1:0]   xfer_dst;
  logic [NCH-1:0]  done;
  logic [NCH-1:0]  irq;
  logic            active;
  logic [2:0]      active_ch;

  int    n_chk = 0;
  int    n_bad = 0;
  item_t exp_q[$];

  always #2 clk = ~clk;

  dma_seq_ctrl #(.NCH(NCH), .AW(AW), .NREQ(NREQ)) i_dma_seq_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req(req), .xfer_valid(xfer_valid), .xfer_ch(xfer_ch),
    .xfer_src(xfer_src), .xfer_dst(xfer_dst), .done(done), .irq(irq),
    .active(active), .active_ch(active_ch)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_ctrl(input bit en, input bit ie, input int mode,
                                            input int rsel, input bit si, input bit di);
    return AW'({di, si, 5'(rsel), 3'(mode), ie, en});
  endfunction

  task automatic wr(input int ch, input int sel, input int data);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = AW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int code);
    req[code] = 1'b1;
    @(negedge clk);
    req[code] = 1'b0;
  endtask

  task automatic expect_words(input int ch, input int s0, input bit si,
                              input int d0, input bit di, input int n);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.ch = ch; it.src = s0 + (si ? k : 0); it.dst = d0 + (di ? k : 0);
      exp_q.push_back(it);
    end
  endtask

  task automatic drain(input string tag);
    repeat (14) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && xfer_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R6 unexpected command", int'(xfer_src), -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(int'(xfer_ch) == it.ch, "R11 channel order", int'(xfer_ch), it.ch);
        chk(int'(xfer_src) == it.src, "R8 source address", int'(xfer_src), it.src);
        chk(int'(xfer_dst) == it.dst, "R8 destination address", int'(xfer_dst), it.dst);
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    chk(xfer_valid == 1'b0, "R13 xfer_valid", int'(xfer_valid), 0);
    chk(done == '0, "R13 done", int'(done), 0);
    chk(irq == '0 && active == 1'b0, "R13 irq/active", int'({irq, active}), 0);

    // R1 R2 R7 R8: block mode on channel 0
    wr(0, 1, 3); wr(0, 2, 'h100); wr(0, 3, 'h200);
    wr(0, 0, int'(mk_ctrl(1, 1, 0, 2, 1, 1)));
    chk(done[0] == 1'b0, "R9 done clear after enable", int'(done[0]), 0);
    expect_words(0, 'h100, 1, 'h200, 1, 3);
    pulse(2);
    drain("R2 block words");
    chk(done[0] == 1'b1, "R2 done at block end", int'(done[0]), 1);
    chk(irq[0] == 1'b1, "R9 irq raised", int'(irq[0]), 1);
    pulse(2);
    drain("R2 enable cleared, no restart");

    // R7 reload, R9 re-enable clears done
    wr(0, 0, int'(mk_ctrl(1, 1, 0, 2, 1, 1)));
    chk(done[0] == 1'b0 && irq[0] == 1'b0, "R9 enable clears done", int'({done[0], irq[0]}), 0);
    expect_words(0, 'h103, 1, 'h203, 1, 3);
    pulse(2);
    drain("R7 counter reloaded");

    // R3 word mode, fixed source
    wr(1, 1, 2); wr(1, 2, 'h40); wr(1, 3, 'h80);
    wr(1, 0, int'(mk_ctrl(1, 1, 1, 5, 0, 1)));
    expect_words(1, 'h40, 0, 'h80, 1, 1);
    pulse(5);
    drain("R3 one word per trigger");
    chk(done[1] == 1'b0, "R3 no done mid block", int'(done[1]), 0);
    expect_words(1, 'h40, 0, 'h81, 1, 1);
    pulse(5);
    drain("R3 second word");
    chk(done[1] == 1'b1 && irq[1] == 1'b1, "R3 done after last word", int'({done[1], irq[1]}), 3);

    // R2 line mode behaves as block
    wr(2, 1, 2); wr(2, 2, 'h300); wr(2, 3, 'h310);
    wr(2, 0, int'(mk_ctrl(1, 0, 2, 7, 1, 1)));
    expect_words(2, 'h300, 1, 'h310, 1, 2);
    pulse(7);
    drain("R2 line mode words");
    chk(done[2] == 1'b1 && irq[2] == 1'b0, "R2/R9 line done, no irq without ie", int'({done[2], irq[2]}), 2);

    // R4 software start
    wr(3, 1, 2); wr(3, 2, 'h500); wr(3, 3, 'h600);
    expect_words(3, 'h500, 1, 'h600, 1, 2);
    wr(3, 0, int'(mk_ctrl(1, 1, 3, 0, 1, 1)));
    drain("R4 start without request");
    chk(done[3] == 1'b1, "R4 done", int'(done[3]), 1);

    // R5 armed mode
    wr(0, 1, 2); wr(0, 2, 'h700); wr(0, 3, 'h710);
    wr(0, 0, int'(mk_ctrl(1, 1, 4, 2, 1, 1)));
    expect_words(0, 'h700, 1, 'h710, 1, 2);
    pulse(2);
    drain("R5 first block");
    chk(done[0] == 1'b0 && irq[0] == 1'b0, "R5 no done at block end", int'({done[0], irq[0]}), 0);
    expect_words(0, 'h702, 1, 'h712, 1, 2);
    pulse(2);
    drain("R5 stays armed");
    wr(0, 0, int'(mk_ctrl(0, 1, 4, 2, 1, 1)));
    chk(done[0] == 1'b1 && irq[0] == 1'b1, "R10 idle disable sets done", int'({done[0], irq[0]}), 3);

    // R6 reserved source code
    wr(1, 0, int'(mk_ctrl(1, 1, 0, 25, 1, 1)));
    req = '1;
    @(negedge clk);
    req = '0;
    drain("R6 reserved code never starts");
    chk(active == 1'b0 && done[1] == 1'b0, "R6 channel idle", int'({active, done[1]}), 0);
    wr(1, 0, int'(mk_ctrl(0, 1, 0, 25, 1, 1)));

    // R11 R12 priority on a shared request
    wr(0, 1, 2); wr(0, 2, 'h800); wr(0, 3, 'h900);
    wr(1, 1, 2); wr(1, 2, 'hA00); wr(1, 3, 'hB00);
    wr(0, 0, int'(mk_ctrl(1, 0, 0, 3, 1, 1)));
    wr(1, 0, int'(mk_ctrl(1, 0, 0, 3, 1, 1)));
    expect_words(0, 'h800, 1, 'h900, 1, 2);
    expect_words(1, 'hA00, 1, 'hB00, 1, 2);
    pulse(3);
    chk(active == 1'b1 && active_ch == 3'd0, "R12 lowest active", int'({active, active_ch}), 8);
    @(negedge clk);
    @(negedge clk);
    chk(active == 1'b1 && active_ch == 3'd1, "R12 service passes to ch1", int'({active, active_ch}), 9);
    drain("R11 priority order");
    chk(active == 1'b0, "R12 idle after", int'(active), 0);

    // R10 disable mid block
    wr(2, 1, 8); wr(2, 2, 'hC00); wr(2, 3, 'hD00);
    wr(2, 0, int'(mk_ctrl(1, 1, 0, 9, 1, 1)));
    expect_words(2, 'hC00, 1, 'hD00, 1, 3);
    pulse(9);
    @(negedge clk);
    @(negedge clk);
    wr(2, 0, int'(mk_ctrl(0, 1, 0, 9, 1, 1)));
    chk(done[2] == 1'b1 && irq[2] == 1'b1, "R10 done after mid-block disable", int'({done[2], irq[2]}), 3);
    chk(active == 1'b0, "R10 channel stopped", int'(active), 0);
    drain("R10 word in flight completes, no more");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule